// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a 36-bit-wide synchronous burst SRAM with flow-through reads. Every control, address and data input is captured on the rising clock edge. An access starts when one of two address strobes loads a new external address. The first strobe is intended for a processor and always performs a read. The second is intended for a cache controller and may read or write. After the load, a two-bit linear burst counter replaces the two low address bits. An advance input steps that counter or holds it to insert wait states.

Read data is not registered on the way out. After the edge that registers an address, the addressed word appears on `dout` through combinational logic in the same cycle. An asynchronous active-low output enable gates the output drive. Writes are selected in one of two ways: a global write that stores all 36 bits, or four byte-lane enables that each store one 9-bit lane, parity bit included. Three chip enables are sampled only when an address is loaded. They decide whether the device is selected or deselected until the next load.

The array depth is set by `ADDR_W`. The default of 8 keeps elaboration small. A value of 16 gives the full 64K-word array.

Top module: `burst_sram_ft`

## Requirements
- R1: When `ld_cpu_n` is LOW and `en_a_n` is LOW at an edge, `addr` is registered and the word at that address is read. No write occurs in that cycle, whatever `wr_all_n`, `wr_lane_n`, `lane_n` and `ld_ctl_n` are doing.
- R2: When `en_a_n` is HIGH, a LOW `ld_cpu_n` is ignored. If `ld_ctl_n` is also HIGH, no address is loaded and the selection state does not change.
- R3: When `ld_ctl_n` is LOW and no processor load happens, `addr` is registered. If the device is selected, that cycle writes according to the write controls.
- R4: The device is selected when, at a loading edge, `en_a_n` is LOW, `en_b` is HIGH and `en_c_n` is LOW. The enables are ignored at all other edges.
- R5: While the device is deselected, `dout_drive` is LOW, `dout` is zero and no write occurs.
- R6: In a cycle with no load, a LOW `step_n` adds one to the two low address bits. The count wraps from 3 to 0 and the upper address bits do not change.
- R7: In a cycle with no load, a HIGH `step_n` holds the address. Any write in that cycle goes to the same address again.
- R8: In the cycle that follows a processor load, `step_n` is treated as HIGH.
- R9: A LOW `wr_all_n` in a selected write cycle stores all 36 bits, whatever `wr_lane_n` and `lane_n` are doing.
- R10: When `wr_all_n` is HIGH and `wr_lane_n` is LOW, each LOW bit of `lane_n` stores its lane and each HIGH bit leaves its lane unchanged. The lane mapping is: bit 0 to data bits 8:0, bit 1 to 17:9, bit 2 to 26:18, and bit 3 to 35:27.
- R11: When both `wr_all_n` and `wr_lane_n` are HIGH, the cycle is a read and stores nothing.
- R12: `out_en_n` acts without a clock. When it is HIGH, `dout_drive` is LOW and `dout` is zero.
- R13: After reset the device is deselected, the registered address is zero and `dout_drive` is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| ld_cpu_n | input | 1 | Processor address strobe, active LOW, read-only load |
| ld_ctl_n | input | 1 | Controller address strobe, active LOW |
| step_n | input | 1 | Burst advance, LOW steps and HIGH waits |
| en_a_n | input | 1 | Primary chip enable, active LOW, also qualifies `ld_cpu_n` |
| en_b | input | 1 | Chip enable, active HIGH |
| en_c_n | input | 1 | Chip enable, active LOW |
| wr_all_n | input | 1 | Global write of all 36 bits, active LOW |
| wr_lane_n | input | 1 | Lane write permit, active LOW |
| lane_n | input | 4 | Per-lane write enables, active LOW |
| out_en_n | input | 1 | Asynchronous output enable, active LOW |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_drive | output | 1 | HIGH while the output would be driven |

## Verification
The hardest situations to reach from the ports are the ones where several controls conflict in one cycle. Examples are a processor load with the write controls active, a LOW processor strobe while the primary enable is HIGH, and a burst continuation in the cycle right after a processor load. Each of these has its own directed task. The task first puts a known word at a known address with a controller-strobe write. It then applies the conflicting inputs and reads the affected addresses back with processor loads, so that a wrongly taken write or step shows up as a changed word. The wrap of the burst is reached by starting a write burst at low bits 2 and reading back all four words.

// File: rtl/burst_sram_pkg.sv
// Package: shared geometry for the flow-through burst SRAM model.
// Assumes a data word made of equal-width lanes, each lane carrying its
// own parity bit as the top bit of the lane.
package burst_sram_pkg;
    localparam int LANES     = 4;
    localparam int LANE_W    = 9;
    localparam int DATA_W    = LANES * LANE_W;
    localparam int BURST_W   = 2;
endpackage

// File: rtl/burst_sram_addr_ctl.sv
// Module: address front end of the burst SRAM.
// Decodes the two address strobes and registers the chip selection on
// loads only. Keeps the two-bit linear burst counter in the low address
// bits and forces a hold in the cycle after a processor load.
// Outputs the address used by the current edge (eff_addr) and a write
// permit for the write decoder.
// Assumes ADDR_W > BURST_W.
module burst_sram_addr_ctl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ld_cpu_n,
    input  logic              ld_ctl_n,
    input  logic              step_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              sel_q,
    output logic              cpu_q,
    output logic              write_ok
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic              ld_p;
    logic              ld_c;
    logic              ld_any;
    logic              sel_next;
    logic              do_step;
    logic [BURST_W-1:0] cnt_next;

    // Decode the strobes, selection and next address for this edge.
    always_comb begin
        ld_p     = !ld_cpu_n && !en_a_n;
        ld_c     = !ld_ctl_n && !ld_p;
        ld_any   = ld_p || ld_c;
        sel_next = ld_any ? (!en_a_n && en_b && !en_c_n) : sel_q;
        do_step  = !ld_any && !cpu_q && !step_n;
        cnt_next = addr_q[BURST_W-1:0] + BURST_W'(1);
        if (ld_any)
            eff_addr = addr;
        else if (do_step)
            eff_addr = {addr_q[ADDR_W-1:BURST_W], cnt_next};
        else
            eff_addr = addr_q;
        write_ok = sel_next && !ld_p;
    end

    // Register the address, the selection and the processor-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
            cpu_q  <= 1'b0;
        end else begin
            addr_q <= eff_addr;
            sel_q  <= sel_next;
            cpu_q  <= ld_p;
        end
    end

    logic unused_hi;
    assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b1;
    logic unused_ok;
    assign unused_ok = unused_hi;
endmodule

// File: rtl/burst_sram_wr_decode.sv
// Module: write-lane decoder.
// Turns the global write, the lane write permit and the per-lane enables
// into one write strobe per lane. Global write wins over the lane enables.
// Assumes write_ok already folds in selection and the processor-load rule.
module burst_sram_wr_decode
    import burst_sram_pkg::*;
(
    input  logic             write_ok,
    input  logic             wr_all_n,
    input  logic             wr_lane_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane g is stored on a global write or on its own enable.
        always_comb begin
            lane_we[g] = write_ok && (!wr_all_n || (!wr_lane_n && !lane_n[g]));
        end
    end
endmodule

// File: rtl/burst_sram_array.sv
// Module: storage array with per-lane synchronous writes and an
// asynchronous read port, which gives the flow-through read path.
// Assumes the contents are not reset; they are undefined until written.
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store each enabled lane at the write address.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (lane_we[l])
                mem[wr_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
    end

    // Read the registered address without a clock.
    always_comb begin
        rdata = mem[rd_addr];
    end
endmodule

// File: rtl/burst_sram_ft.sv
// Module: top of the flow-through synchronous burst SRAM model.
// Ties together the address front end, the write decoder and the array.
// The output drive depends on the registered selection and, without a
// clock, on out_en_n.
// Assumes the external bus logic merges din, dout and dout_drive into one
// bidirectional bus.
module burst_sram_ft
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ld_cpu_n,
    input  logic              ld_ctl_n,
    input  logic              step_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              wr_all_n,
    input  logic              wr_lane_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] addr_q;
    logic              sel_q;
    logic              cpu_q;
    logic              write_ok;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] rdata;

    burst_sram_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ld_cpu_n (ld_cpu_n),
        .ld_ctl_n (ld_ctl_n),
        .step_n   (step_n),
        .en_a_n   (en_a_n),
        .en_b     (en_b),
        .en_c_n   (en_c_n),
        .eff_addr (eff_addr),
        .addr_q   (addr_q),
        .sel_q    (sel_q),
        .cpu_q    (cpu_q),
        .write_ok (write_ok)
    );

    burst_sram_wr_decode u_wr (
        .write_ok  (write_ok),
        .wr_all_n  (wr_all_n),
        .wr_lane_n (wr_lane_n),
        .lane_n    (lane_n),
        .lane_we   (lane_we)
    );

    burst_sram_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_addr (eff_addr),
        .lane_we (lane_we),
        .wdata   (din),
        .rd_addr (addr_q),
        .rdata   (rdata)
    );

    // Gate the read data with the selection and the output enable.
    always_comb begin
        dout_drive = sel_q && !out_en_n;
        dout       = dout_drive ? rdata : '0;
    end
endmodule

// File: rtl/burst_sram_ft_chk.sv
// Module: assertion checker for burst_sram_ft, attached with bind.
// Observes the ports and the registered address and selection state.
// Assumes ADDR_W > 2.
module burst_sram_ft_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ld_cpu_n,
    input logic              ld_ctl_n,
    input logic              step_n,
    input logic              en_a_n,
    input logic              en_b,
    input logic              en_c_n,
    input logic              wr_all_n,
    input logic              out_en_n,
    input logic              dout_drive,
    input logic [ADDR_W-1:0] addr_q,
    input logic              sel_q,
    input logic              cpu_q,
    input logic [LANES-1:0]  lane_we
);
    logic cpu_fire;
    logic any_fire;
    logic en_ok;

    // Recompute the load conditions from the ports.
    always_comb begin
        cpu_fire = !ld_cpu_n && !en_a_n;
        any_fire = cpu_fire || !ld_ctl_n;
        en_ok    = !en_a_n && en_b && !en_c_n;
    end

    assert_cpu_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fire |=> addr_q == $past(addr));

    assert_cpu_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fire |-> lane_we == '0);

    assert_cpu_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_cpu_n && en_a_n && ld_ctl_n) |=> $stable(sel_q));

    assert_deselect_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((any_fire && !en_ok) || (!any_fire && !sel_q)) |-> lane_we == '0);

    assert_deselect_nodrive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !dout_drive);

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_fire && !cpu_q && !step_n) |=>
            (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) &&
            (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_fire && step_n) |=> $stable(addr_q));

    assert_after_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_q && !any_fire) |=> $stable(addr_q));

    assert_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_fire && sel_q && !wr_all_n) |-> lane_we == '1);

    assert_oe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_drive);
endmodule

bind burst_sram_ft burst_sram_ft_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_sram_ft_test.sv
// Directed bench for burst_sram_ft: one task per scenario.
module burst_sram_ft_test;
    localparam int CLK_P = 10;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ld_cpu_n, ld_ctl_n, step_n;
    logic          en_a_n, en_b, en_c_n;
    logic          wr_all_n, wr_lane_n;
    logic [3:0]    lane_n;
    logic          out_en_n;
    logic [35:0]   din;
    logic [35:0]   dout;
    logic          dout_drive;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_sram_ft #(.ADDR_W(AW)) uut (.*);

    localparam logic [35:0] W10 = 36'h1_2345_6789;
    localparam logic [35:0] B0  = 36'hA_0000_0022;
    localparam logic [35:0] B1  = 36'hA_0000_0023;
    localparam logic [35:0] B2  = 36'hA_0000_0020;
    localparam logic [35:0] B3  = 36'hA_0000_0021;
    localparam logic [35:0] ONES = 36'hF_FFFF_FFFF;
    localparam logic [35:0] FIVES = 36'h5_5555_5555;

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic idle();
        ld_cpu_n = 1; ld_ctl_n = 1; step_n = 1;
        en_a_n = 0; en_b = 1; en_c_n = 0;
        wr_all_n = 1; wr_lane_n = 1; lane_n = 4'hF;
        out_en_n = 0; din = '0; addr = '0;
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [AW-1:0] a, input logic [35:0] d);
        ld_ctl_n = 0; addr = a; wr_all_n = 0; din = d;
        tick();
        idle();
    endtask

    task automatic cpu_read(input logic [AW-1:0] a);
        ld_cpu_n = 0; addr = a;
        tick();
        idle();
    endtask

    task automatic expect_word(input string tag, input logic [35:0] exp);
        check(dout_drive === 1'b1 && dout === exp, tag, dout, exp);
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        repeat (3) tick();
        check(dout_drive === 1'b0 && dout === '0, "R13 reset deselected", dout, '0);
        rst_n = 1;
        tick();
        check(dout_drive === 1'b0, "R13 idle after reset", {35'd0, dout_drive}, '0);
    endtask

    task automatic t_global_write();
        ctl_write(8'h10, W10);
        expect_word("R3 controller write flows through", W10);
        cpu_read(8'h10);
        expect_word("R1 R9 processor read of full word", W10);
    endtask

    task automatic t_burst_wrap();
        ctl_write(8'h22, B0);
        step_n = 0; wr_all_n = 0;
        din = B1; tick();
        din = B2; tick();
        din = B3; tick();
        idle();
        cpu_read(8'h22); expect_word("R6 burst word 2", B0);
        cpu_read(8'h23); expect_word("R6 burst word 3", B1);
        cpu_read(8'h20); expect_word("R6 wrap to 0", B2);
        cpu_read(8'h21); expect_word("R6 word 1 after wrap", B3);
    endtask

    task automatic t_adv_after_cpu();
        cpu_read(8'h20);
        expect_word("R1 read start", B2);
        step_n = 0; tick();
        expect_word("R8 step ignored after processor load", B2);
        step_n = 0; tick();
        expect_word("R6 step after hold", B3);
        step_n = 1; tick();
        expect_word("R7 wait state holds read", B3);
        idle();
    endtask

    task automatic t_wait_write();
        ctl_write(8'h61, 36'h0_CCCC_CCCC);
        ctl_write(8'h60, 36'h0_AAAA_AAAA);
        step_n = 1; wr_all_n = 0; din = 36'h0_BBBB_BBBB;
        tick(); idle();
        cpu_read(8'h60); expect_word("R7 wait write repeats address", 36'h0_BBBB_BBBB);
        cpu_read(8'h61); expect_word("R7 next word untouched", 36'h0_CCCC_CCCC);
    endtask

    task automatic t_lanes();
        logic [35:0] exp;
        exp = {9'h1FF, 9'h000, 9'h1FF, 9'h000};
        ctl_write(8'h30, ONES);
        ld_ctl_n = 0; addr = 8'h30; wr_lane_n = 0; lane_n = 4'b1010; din = '0;
        tick(); idle();
        expect_word("R10 lanes 0 and 2 written", exp);
        ld_ctl_n = 0; addr = 8'h30; wr_all_n = 0; wr_lane_n = 1; lane_n = 4'hF;
        din = FIVES;
        tick(); idle();
        expect_word("R9 global write beats lane enables", FIVES);
        ld_ctl_n = 0; addr = 8'h30; lane_n = 4'h0; din = '0;
        tick(); idle();
        expect_word("R11 no write without permit", FIVES);
    endtask

    task automatic t_cpu_no_write();
        ld_cpu_n = 0; ld_ctl_n = 0; addr = 8'h30; wr_all_n = 0; wr_lane_n = 0;
        lane_n = 4'h0; din = '0;
        tick(); idle();
        expect_word("R1 processor load does not write", FIVES);
        cpu_read(8'h30);
        expect_word("R1 word intact on reread", FIVES);
    endtask

    task automatic t_cpu_ignored();
        cpu_read(8'h10);
        ld_cpu_n = 0; en_a_n = 1; addr = 8'h30;
        tick(); idle();
        expect_word("R2 processor strobe ignored", W10);
    endtask

    task automatic t_deselect();
        ld_ctl_n = 0; en_b = 0; addr = 8'h10; wr_all_n = 0; din = 36'hD_EAD0_0000;
        tick();
        check(dout_drive === 1'b0 && dout === '0, "R5 R4 deselect by en_b", dout, '0);
        ld_ctl_n = 1; en_b = 1; step_n = 0; din = 36'hD_EAD0_0001;
        tick(); idle();
        check(dout_drive === 1'b0, "R5 stays deselected", {35'd0, dout_drive}, '0);
        cpu_read(8'h10); expect_word("R5 no write while deselected", W10);
        cpu_read(8'h11);
        check(dout === dout && dout_drive === 1'b1, "R5 reselect by load", {35'd0, dout_drive}, 36'd1);
        ld_ctl_n = 0; en_c_n = 1; addr = 8'h10;
        tick(); idle();
        check(dout_drive === 1'b0, "R4 deselect by en_c_n", {35'd0, dout_drive}, '0);
        ld_ctl_n = 0; en_a_n = 1; addr = 8'h10;
        tick(); idle();
        check(dout_drive === 1'b0, "R4 controller load with en_a_n HIGH", {35'd0, dout_drive}, '0);
    endtask

    task automatic t_enables_on_load_only();
        cpu_read(8'h10);
        en_b = 0; en_c_n = 1; en_a_n = 1;
        tick(); idle();
        expect_word("R4 enables ignored without load", W10);
    endtask

    task automatic t_oe();
        cpu_read(8'h10);
        out_en_n = 1; #1;
        check(dout_drive === 1'b0 && dout === '0, "R12 output gated without clock", dout, '0);
        out_en_n = 0; #1;
        expect_word("R12 output back without clock", W10);
    endtask

    initial begin
        t_reset();
        t_global_write();
        t_burst_wrap();
        t_adv_after_cpu();
        t_wait_write();
        t_lanes();
        t_cpu_no_write();
        t_cpu_ignored();
        t_deselect();
        t_enables_on_load_only();
        t_oe();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule